// File: doc/BRIEF.md
# Tone Cadence Timer Controller

This block switches two tone oscillators on and off in a repeating pattern. Each generator has two period timers. The on-period timer runs while the tone sounds. The off-period timer runs while the tone is silent. When one timer reaches its programmed length, the other timer starts. The timers count a sample-rate tick, so period lengths are given in samples. The oscillators sit outside this block and only see a gate signal.

Every timer expiry records a pending flag. The four flags are masked by an enable register, and any enabled flag drives a single interrupt line. Software writes period lengths, generator enables and interrupt enables through a simple register port. It clears pending flags by writing ones to the status register.

Top module: `tone_cadence_ctrl`

## Requirements
- R1: After reset, both gates and the interrupt line are low, and every register reads back as zero.
- R2: A generator whose enable bit is 0 holds its gate low. The enables are bit 0 (generator 1) and bit 1 (generator 2) of the control register at address 0.
- R3: When a generator is enabled and both of its lengths are non-zero, the gate is high for exactly its on-length sample ticks, then low for exactly its off-length ticks, and this alternation repeats. Enabling the generator starts the on period.
- R4: If either length of an enabled generator is zero, its gate stays high continuously and its timers record no expiry.
- R5: Each expiry sets its own pending bit, in this order: bit 0 = generator 1 on-period end, bit 1 = generator 1 off-period end, bit 2 = generator 2 on-period end, bit 3 = generator 2 off-period end. A bit is set even when its interrupt is disabled.
- R6: The interrupt line is high exactly when some pending bit is set and its interrupt enable bit is set. The enable register is at address 1 and uses the same bit order as the pending bits.
- R7: Writing to the status register at address 2 clears each pending bit written as 1. Bits written as 0 keep their value.
- R8: When an expiry and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: Clearing a generator's enable and setting it again restarts the cadence at the beginning of the on period.
- R10: Period lengths are at addresses 4 (generator 1 on), 5 (generator 1 off), 6 (generator 2 on) and 7 (generator 2 off). All registers read back what was written. Address 3 reads as zero and ignores writes.
- R11: Timers advance only on cycles where the sample tick is high. Without ticks and without register writes, the gates do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tone_gate | output | 2 | Gate for each oscillator, bit 0 = generator 1 |
| irq | output | 1 | Interrupt request |

## Verification
A timer expiry and a write-one-to-clear can act on the same pending bit in the same cycle. The bench provokes this by tracking its own model of generator 1's count. It issues the clearing write on exactly the cycle whose tick ends the on period. It then reads the status register and expects the on-period bit set and the other bits cleared. The same collision also arises many times in the random phase, where every cycle's gate and interrupt level are compared with the model.

// File: rtl/tcad_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the tone cadence controller.
// Assumes exactly two generators; the pending/enable bit order depends on it.
package tcad_pkg;
    localparam int unsigned NUM_GEN = 2;
    localparam int unsigned NUM_EVT = 2 * NUM_GEN;
    localparam int unsigned ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_RLD0 = 3'd4;

    typedef enum logic {
        PH_ACTIVE   = 1'b0,
        PH_INACTIVE = 1'b1
    } phase_e;
endpackage

// File: rtl/tcad_regs.sv
`timescale 1ns/1ps
// Holds the generator enables and the four period lengths.
// Assumes the lengths sit at consecutive addresses from ADDR_RLD0,
// in the order gen*2 + phase.
module tcad_regs
    import tcad_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [REG_W-1:0]                  wdata,
    output logic [NUM_GEN-1:0]                gen_en,
    output logic [NUM_EVT-1:0][REG_W-1:0]     reload
);

    // Control register: one enable bit per generator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= '0;
        end else if (wr_en && addr == ADDR_CTRL) begin
            gen_en <= wdata[NUM_GEN-1:0];
        end
    end

    for (genvar r = 0; r < NUM_EVT; r++) begin : g_rld
        localparam logic [ADDR_W-1:0] RLD_ADDR = ADDR_W'(int'(ADDR_RLD0) + r);

        // Length register for one timer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload[r] <= '0;
            end else if (wr_en && addr == RLD_ADDR) begin
                reload[r] <= wdata;
            end
        end
    end

endmodule

// File: rtl/tcad_timer.sv
`timescale 1ns/1ps
// Cadence engine for one generator: on/off timers that alternate.
// Assumes lengths are counted in sample ticks. A zero length disables
// cadencing, so the gate follows the enable alone.
module tcad_timer
    import tcad_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] act_len,
    input  logic [CNT_W-1:0] inact_len,
    output logic             gate,
    output logic [1:0]       expire
);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_len;
    logic             cad_on;
    logic             last;
    logic             step;

    // Decode which timer runs and whether this tick ends its period.
    always_comb begin
        cad_on  = (act_len != '0) && (inact_len != '0);
        cur_len = (ph_q == PH_ACTIVE) ? act_len : inact_len;
        last    = ({1'b0, cnt_q} + (CNT_W + 1)'(1)) >= {1'b0, cur_len};
        step    = enable && cad_on && tick;
    end

    // Phase and count; disabled or non-cadenced returns to on-period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_ACTIVE;
            cnt_q <= '0;
        end else if (!enable || !cad_on) begin
            ph_q  <= PH_ACTIVE;
            cnt_q <= '0;
        end else if (tick) begin
            if (last) begin
                ph_q  <= (ph_q == PH_ACTIVE) ? PH_INACTIVE : PH_ACTIVE;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Expiry pulses (bit 0 on-period, bit 1 off-period) and the gate.
    always_comb begin
        expire[0] = step && last && (ph_q == PH_ACTIVE);
        expire[1] = step && last && (ph_q == PH_INACTIVE);
        gate      = enable && (!cad_on || ph_q == PH_ACTIVE);
    end

endmodule

// File: rtl/tcad_irq.sv
`timescale 1ns/1ps
// Interrupt enable and pending flags with write-one-to-clear.
// Assumes a set event outranks a clear of the same bit in one cycle.
module tcad_irq
    import tcad_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ien_wr,
    input  logic               stat_wr,
    input  logic [NUM_EVT-1:0] wbits,
    input  logic [NUM_EVT-1:0] set_evt,
    output logic [NUM_EVT-1:0] ien,
    output logic [NUM_EVT-1:0] stat,
    output logic               irq
);

    logic [NUM_EVT-1:0] clr_mask;

    // Bits a status write asks to clear.
    always_comb begin
        clr_mask = stat_wr ? wbits : '0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= wbits;
        end
    end

    // Pending flags: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr_mask) | set_evt;
        end
    end

    // Request line from enabled pending flags.
    always_comb begin
        irq = |(stat & ien);
    end

endmodule

// File: rtl/tone_cadence_ctrl.sv
`timescale 1ns/1ps
// Top of the tone cadence controller: register port, two cadence engines
// and interrupt logic. Assumes reg_rdata is sampled by the host while
// reg_addr is held. Addresses not decoded read as zero.
module tone_cadence_ctrl
    import tcad_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_GEN-1:0]   tone_gate,
    output logic                 irq
);

    logic [NUM_GEN-1:0]            gen_en;
    logic [NUM_EVT-1:0][REG_W-1:0] reload;
    logic [NUM_EVT-1:0]            evt;
    logic [NUM_EVT-1:0]            int_en;
    logic [NUM_EVT-1:0]            int_stat;

    tcad_regs #(.REG_W(REG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .gen_en (gen_en),
        .reload (reload)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        tcad_timer #(.CNT_W(REG_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (sample_tick),
            .enable    (gen_en[g]),
            .act_len   (reload[2*g]),
            .inact_len (reload[2*g+1]),
            .gate      (tone_gate[g]),
            .expire    (evt[2*g +: 2])
        );
    end

    tcad_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (reg_wr && reg_addr == ADDR_IEN),
        .stat_wr (reg_wr && reg_addr == ADDR_STAT),
        .wbits   (reg_wdata[NUM_EVT-1:0]),
        .set_evt (evt),
        .ien     (int_en),
        .stat    (int_stat),
        .irq     (irq)
    );

    // Read-back multiplexer over all registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = REG_W'(gen_en);
            ADDR_IEN:  reg_rdata = REG_W'(int_en);
            ADDR_STAT: reg_rdata = REG_W'(int_stat);
            default: begin
                for (int r = 0; r < NUM_EVT; r++) begin
                    if (reg_addr == ADDR_W'(int'(ADDR_RLD0) + r)) begin
                        reg_rdata = reload[r];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/tcad_checker.sv
`timescale 1ns/1ps
// Protocol checks for the tone cadence controller, attached by bind.
// Assumes access to the pending flags of the top module.
module tcad_checker
    import tcad_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_tick,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [NUM_GEN-1:0] tone_gate,
    input logic               irq,
    input logic [NUM_EVT-1:0] stat
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (tone_gate == '0 && !irq));

    assert_gate1_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[0]) |=> !tone_gate[0]);

    assert_gate2_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[1]) |=> !tone_gate[1]);

    assert_gate1_fall_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tone_gate[0]) && !$past(reg_wr)) |-> stat[0]);

    assert_gate2_fall_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tone_gate[1]) && !$past(reg_wr)) |-> stat[2]);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_IEN && reg_wdata[NUM_EVT-1:0] == '0) |=> !irq);

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[NUM_EVT-1:0] == '1 && !sample_tick)
        |=> stat == '0);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tone_gate[0]) && $past(reg_wr && reg_addr == ADDR_STAT)) |-> stat[0]);

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !reg_wr) |=> $stable(tone_gate));

endmodule

bind tone_cadence_ctrl tcad_checker #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .tone_gate   (tone_gate),
    .irq         (irq),
    .stat        (int_stat)
);

// File: tb/tone_cadence_ctrl_tb_top.sv
`timescale 1ns/1ps
module tone_cadence_ctrl_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [1:0]   gate;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    tone_cadence_ctrl #(.REG_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .reg_wr(wr),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .tone_gate(gate), .irq(irq)
    );

    // Reference model built from the requirements.
    logic [1:0]   m_en;
    logic [3:0]   m_ien;
    logic [3:0]   m_stat;
    logic [W-1:0] m_rl [4];
    logic         m_ph [2];
    logic [W-1:0] m_cnt [2];

    function automatic bit m_cad(int g);
        return (m_rl[2*g] != 0) && (m_rl[2*g+1] != 0);
    endfunction

    function automatic bit m_last(int g);
        int len;
        len = int'(m_rl[2*g + int'(m_ph[g])]);
        return (int'(m_cnt[g]) + 1) >= len;
    endfunction

    function automatic bit m_gate(int g);
        return m_en[g] && (!m_cad(g) || !m_ph[g]);
    endfunction

    function automatic logic [W-1:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return W'(m_en);
            3'd1: return W'(m_ien);
            3'd2: return W'(m_stat);
            3'd4, 3'd5, 3'd6, 3'd7: return m_rl[int'(a) - 4];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_ien = '0; m_stat = '0;
            for (int i = 0; i < 4; i++) m_rl[i] = '0;
            for (int g = 0; g < 2; g++) begin m_ph[g] = 1'b0; m_cnt[g] = '0; end
        end else begin
            logic [3:0] s;
            s = '0;
            for (int g = 0; g < 2; g++) begin
                if (!m_en[g] || !m_cad(g)) begin
                    m_ph[g] = 1'b0; m_cnt[g] = '0;
                end else if (tick) begin
                    if (m_last(g)) begin
                        s[2*g + int'(m_ph[g])] = 1'b1;
                        m_ph[g] = ~m_ph[g]; m_cnt[g] = '0;
                    end else begin
                        m_cnt[g] = m_cnt[g] + 1'b1;
                    end
                end
            end
            if (wr && addr == 3'd2) m_stat = m_stat & ~wdata[3:0];
            m_stat = m_stat | s;
            if (wr) begin
                case (addr)
                    3'd0: m_en = wdata[1:0];
                    3'd1: m_ien = wdata[3:0];
                    3'd4, 3'd5, 3'd6, 3'd7: m_rl[int'(addr) - 4] = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison of gates and interrupt against the model.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk(gate == {m_gate(1), m_gate(0)}, "R3 gate", 32'(gate),
                32'({m_gate(1), m_gate(0)}));
            chk(irq == |(m_stat & m_ien), "R6 irq", 32'(irq), 32'(|(m_stat & m_ien)));
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk); tick = 1'b0; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [W-1:0] e, input string req);
        @(negedge clk); wr = 1'b0; tick = 1'b0; addr = a;
        #1 chk(rdata == e, req, 32'(rdata), 32'(e));
    endtask

    task automatic rd_model(input logic [2:0] a, input string req);
        @(negedge clk); wr = 1'b0; tick = 1'b0; addr = a;
        #1 chk(rdata == m_read(a), req, 32'(rdata), 32'(m_read(a)));
    endtask

    // Sample gate 0 then tick, for n cycles, against an expected bit pattern.
    task automatic gate_pattern(input logic [15:0] pat, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr = 1'b0;
            chk(gate[0] == pat[n-1-i], req, 32'(gate[0]), 32'(pat[n-1-i]));
            tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        bit hit;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gate == 2'b00, "R1 gates", 32'(gate), 0);
        chk(!irq, "R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd_expect(3'(a), '0, "R1 regs");
        mon_on = 1'b1;

        // R10: register map and readback
        wr_reg(3'd4, 16'd3); wr_reg(3'd5, 16'd2);
        wr_reg(3'd6, 16'd5); wr_reg(3'd7, 16'd4);
        wr_reg(3'd3, 16'hBEEF);
        rd_expect(3'd4, 16'd3, "R10 g1 on");
        rd_expect(3'd5, 16'd2, "R10 g1 off");
        rd_expect(3'd6, 16'd5, "R10 g2 on");
        rd_expect(3'd7, 16'd4, "R10 g2 off");
        rd_expect(3'd3, 16'd0, "R10 unmapped");

        // R2: disabled generator holds gate low under ticks
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); tick = 1'b1;
            chk(gate == 2'b00, "R2 disabled", 32'(gate), 0);
        end
        @(negedge clk); tick = 1'b0;

        // R3: three on, two off, repeating
        wr_reg(3'd0, 16'd1);
        gate_pattern(16'b1110011100, 10, "R3 cadence");

        // R5 with R6 masked: pending bits set, irq low
        rd_expect(3'd2, 16'h3, "R5 pending");
        chk(!irq, "R6 masked", 32'(irq), 0);
        wr_reg(3'd1, 16'h1);
        chk(irq, "R6 enabled", 32'(irq), 1);
        wr_reg(3'd1, 16'h4);
        chk(!irq, "R6 other bit", 32'(irq), 0);

        // R7: selective and full clear
        wr_reg(3'd2, 16'h2);
        rd_expect(3'd2, 16'h1, "R7 partial");
        wr_reg(3'd2, 16'hF);
        rd_expect(3'd2, 16'h0, "R7 full");

        // R8: clear lands on the cycle the on period ends
        hit = 1'b0;
        for (int i = 0; i < 30 && !hit; i++) begin
            @(negedge clk);
            if (m_en[0] && m_cad(0) && !m_ph[0] && m_last(0)) begin
                tick = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 16'hF; hit = 1'b1;
            end else begin
                tick = 1'b1; wr = 1'b0;
            end
        end
        @(negedge clk); wr = 1'b0; tick = 1'b0;
        chk(hit, "R8 collision reached", 32'(hit), 1);
        rd_expect(3'd2, 16'h1, "R8 set wins");

        // R9: disable in off period, re-enable starts on period
        for (int i = 0; i < 30 && !m_ph[0]; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
        chk(m_ph[0] == 1'b1, "R9 in off period", 32'(m_ph[0]), 1);
        wr_reg(3'd0, 16'd0);
        chk(gate[0] == 1'b0, "R2 disable", 32'(gate[0]), 0);
        wr_reg(3'd0, 16'd1);
        gate_pattern(16'b1110, 4, "R9 restart");

        // R4: zero off-length keeps gate on with no pending
        wr_reg(3'd5, 16'd0);
        wr_reg(3'd2, 16'hF);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); tick = 1'b1;
            chk(gate[0] == 1'b1, "R4 steady", 32'(gate[0]), 1);
        end
        rd_expect(3'd2, 16'h0, "R4 no pending");

        // R11: no ticks, no change
        wr_reg(3'd5, 16'd2);
        wr_reg(3'd0, 16'd3);
        repeat (7) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        held = gate;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(gate == held, "R11 hold", 32'(gate), 32'(held));
        end
        rd_model(3'd2, "R5 both generators");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [2:0] a;
            sel = int'($urandom % 8);
            if (sel == 0) begin
                a = 3'($urandom % 8);
                rd_model(a, "R10 random read");
            end else begin
                @(negedge clk);
                tick = 1'($urandom % 2);
                wr = (sel == 1);
                a = 3'($urandom % 8);
                addr = a;
                wdata = (a >= 3'd4) ? W'($urandom % 5) : W'($urandom % 16);
            end
        end
        @(negedge clk); wr = 1'b0; tick = 1'b0;
        rd_model(3'd2, "R7 final status");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule